// File: doc/BRIEF.md
# Bus error first-capture logger

This block keeps a record of the first error seen on a PCI-style bus so that software can inspect it later. In the bus clock domain it watches an error strobe. In the cycle the strobe first rises, it stores four things from the transaction in flight: the 32-bit address, the 4-bit bus command, the one-hot transfer source and, when the block acts as host, the one-hot arbitration grant. It then locks, and every later strobe is ignored until reset.

Software reads the record through a simple read port clocked by a peripheral clock. That clock has no fixed phase or frequency relation to the bus clock. Once locked, the stored fields never change, so only the lock flag needs to cross the clock boundary, through a flop chain. The read side returns zero for every data field until it has seen the synchronized flag. As a result, software can never see a record that is only half settled.

Top module: `bus_err_logger`

## Requirements
- R1: While either reset is asserted, and after it is released with no error seen, every read returns zero, including the status bit.
- R2: On the first bus-clock cycle in which `err_strobe` is high, the value of `bus_addr` is stored. A read at byte offset 0x0 returns it in bits 31:0.
- R3: The stored `bus_cmd` is returned at offset 0x4 in bits 3:0.
- R4: The stored `xfer_src` is returned at offset 0x4 in bits 13:8. Bit 8 means master PIO, bits 9 to 12 mean DMA channels 0 to 3, and bit 13 means target access. All other bits of that word read as zero.
- R5: If `host_mode` is high in the capture cycle, `req_grant` (bit n for request line n, n = 0 to 4) is stored and returned at offset 0x8 in bits 4:0. If `host_mode` is low, zero is stored.
- R6: After a capture, further strobes are ignored and every stored field keeps its value. This holds for strobes in back-to-back cycles and for strobes that arrive while the flag is still crossing. With back-to-back strobes, the earliest cycle's values are the ones kept.
- R7: Offset 0xC returns the valid flag in bit 0. The flag is visible only after a two-stage synchronizer in the peripheral domain. The data words read as zero until that flag has been seen.
- R8: `rd_data` updates on the `per_clk` edge at which `rd_en` is high and holds its value otherwise. Address bits 1:0 are ignored.
- R9: A reset clears the record and re-arms the block, so the next error after reset is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| err_strobe | input | 1 | Error seen on the current bus cycle |
| bus_addr | input | 32 | Address of the current transaction |
| bus_cmd | input | 4 | Bus command of the current transaction |
| xfer_src | input | 6 | One-hot active transfer source |
| req_grant | input | 5 | One-hot grant to request lines 0 to 4 |
| host_mode | input | 1 | High when the bridge acts as host |
| per_clk | input | 1 | Peripheral clock for the read port |
| per_rst_n | input | 1 | Active-low asynchronous reset, peripheral domain |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Byte offset of the word to read |
| rd_data | output | 32 | Registered read data |

## Verification
The bench drives strobes on several back-to-back cycles, each carrying a different address. A logger that stays armed for one cycle too long would report the second address rather than the first. The bench also raises a second error while the flag is still in the synchronizer, and reads the data words right after an error before the flag has crossed. A design that exposed the fields early, or let the late error overwrite them, would return non-zero or changed values. Captures made with host mode low must report a zero grant, and a reset must re-arm capture rather than leave the block locked.

// File: rtl/bel_pkg.sv
package bel_pkg;
  parameter int ADDR_W = 32;
  parameter int CMD_W  = 4;
  parameter int SRC_N  = 6;
  parameter int REQ_N  = 5;
  parameter int DATA_W = 32;
  parameter int RD_AW  = 4;

  localparam int SRC_LSB = 8;

  typedef enum logic [1:0] {
    W_ADDR   = 2'd0,
    W_CMDSRC = 2'd1,
    W_MASTER = 2'd2,
    W_STATUS = 2'd3
  } word_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
    logic [SRC_N-1:0]  src;
    logic [REQ_N-1:0]  mst;
  } err_rec_t;

  function automatic logic [DATA_W-1:0] bel_word(input word_e sel, input logic vld,
                                                 input err_rec_t rec);
    logic [DATA_W-1:0] w;
    w = '0;
    if (vld) begin
      case (sel)
        W_ADDR:   w[ADDR_W-1:0] = rec.addr;
        W_CMDSRC: begin
          w[CMD_W-1:0] = rec.cmd;
          w[SRC_LSB +: SRC_N] = rec.src;
        end
        W_MASTER: w[REQ_N-1:0] = rec.mst;
        default:  w[0] = 1'b1;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/bel_capture.sv
module bel_capture
  import bel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CMD_W-1:0] bus_cmd,
  input  logic [SRC_N-1:0] xfer_src,
  input  logic [REQ_N-1:0] req_grant,
  input  logic             host_mode,
  output logic             cap_evt,
  output logic             locked,
  output err_rec_t         rec
);
  assign cap_evt = err_strobe & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      rec    <= '0;
    end else if (cap_evt) begin
      locked   <= 1'b1;
      rec.addr <= bus_addr;
      rec.cmd  <= bus_cmd;
      rec.src  <= xfer_src;
      rec.mst  <= host_mode ? req_grant : '0;
    end
  end
endmodule

// File: rtl/bel_sync.sv
module bel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bel_readout.sv
module bel_readout
  import bel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [RD_AW-1:0]  rd_addr,
  input  logic              vld_s,
  input  err_rec_t          rec,
  output logic [DATA_W-1:0] rd_data
);
  word_e sel;
  assign sel = word_e'(rd_addr[3:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= bel_word(sel, vld_s, rec);
  end
endmodule

// File: rtl/bus_err_logger.sv
module bus_err_logger
  import bel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              err_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CMD_W-1:0]  bus_cmd,
  input  logic [SRC_N-1:0]  xfer_src,
  input  logic [REQ_N-1:0]  req_grant,
  input  logic              host_mode,
  input  logic              per_clk,
  input  logic              per_rst_n,
  input  logic              rd_en,
  input  logic [RD_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic     cap_evt;
  logic     locked;
  logic     per_valid;
  err_rec_t rec;

  bel_capture u_cap (
    .clk(bus_clk), .rst_n(bus_rst_n), .err_strobe(err_strobe),
    .bus_addr(bus_addr), .bus_cmd(bus_cmd), .xfer_src(xfer_src),
    .req_grant(req_grant), .host_mode(host_mode),
    .cap_evt(cap_evt), .locked(locked), .rec(rec)
  );

  bel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(per_clk), .rst_n(per_rst_n), .d(locked), .q(per_valid)
  );

  bel_readout u_rd (
    .clk(per_clk), .rst_n(per_rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .vld_s(per_valid), .rec(rec), .rd_data(rd_data)
  );
endmodule

// File: rtl/bel_checker.sv
module bel_checker
  import bel_pkg::*;
(
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              per_clk,
  input logic              per_rst_n,
  input logic              err_strobe,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CMD_W-1:0]  bus_cmd,
  input logic              host_mode,
  input logic              cap_evt,
  input logic              locked,
  input logic              per_valid,
  input err_rec_t          rec,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data
);
  p_capture_addr_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (err_strobe && !locked) |=> (locked && rec.addr == $past(bus_addr)));

  p_capture_cmd_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (err_strobe && !locked) |=> rec.cmd == $past(bus_cmd));

  p_src_onehot_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    locked |-> $onehot0(rec.src));

  p_mst_zero_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (cap_evt && !host_mode) |=> rec.mst == '0);

  p_hold_after_lock_r6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    locked |=> ($stable(rec) && locked));

  p_valid_needs_lock_r7: assert property (@(posedge per_clk)
    disable iff (!per_rst_n || !bus_rst_n) per_valid |-> locked);

  p_rdata_hold_r8: assert property (@(posedge per_clk) disable iff (!per_rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind bus_err_logger bel_checker u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .per_clk(per_clk), .per_rst_n(per_rst_n),
  .err_strobe(err_strobe), .bus_addr(bus_addr), .bus_cmd(bus_cmd), .host_mode(host_mode),
  .cap_evt(cap_evt), .locked(locked), .per_valid(per_valid), .rec(rec),
  .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/bus_err_logger_bench.sv
`timescale 1ns/1ps
module bus_err_logger_bench;
  logic        bus_clk = 0, per_clk = 0;
  logic        bus_rst_n = 0, per_rst_n = 0;
  logic        err_strobe = 0, host_mode = 0, rd_en = 0;
  logic [31:0] bus_addr = 0;
  logic [3:0]  bus_cmd = 0, rd_addr = 0;
  logic [5:0]  xfer_src = 0;
  logic [4:0]  req_grant = 0;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2    bus_clk = ~bus_clk;
  always #3.35 per_clk = ~per_clk;

  bus_err_logger u_bus_err_logger (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge per_clk); rd_en = 1; rd_addr = a;
    @(negedge per_clk); rd_en = 0; d = rd_data;
  endtask

  task automatic do_reset();
    bus_rst_n = 0; per_rst_n = 0;
    repeat (3) @(negedge per_clk);
    bus_rst_n = 1; per_rst_n = 1;
    repeat (2) @(negedge per_clk);
  endtask

  task automatic bus_err(input logic [31:0] a, input logic [3:0] c, input logic [5:0] s,
                         input logic [4:0] g, input logic h);
    @(negedge bus_clk);
    err_strobe = 1; bus_addr = a; bus_cmd = c; xfer_src = s; req_grant = g; host_mode = h;
    @(negedge bus_clk); err_strobe = 0;
  endtask

  task automatic wait_valid();
    logic [31:0] d;
    for (int i = 0; i < 20; i++) begin
      rd(4'hC, d);
      if (d[0]) return;
    end
    check("R7 valid timeout", d, 32'h1);
  endtask

  task automatic expect_rec(input string tag, input logic [31:0] a, input logic [3:0] c,
                            input logic [5:0] s, input logic [4:0] g);
    logic [31:0] d;
    rd(4'h0, d); check({tag, " R2 addr"}, d, a);
    rd(4'h4, d); check({tag, " R3/R4 cmd+src"}, d, {18'd0, s, 4'd0, c});
    rd(4'h8, d); check({tag, " R5 master"}, d, {27'd0, g});
    rd(4'hF, d); check({tag, " R7/R8 status, low addr bits ignored"}, d, 32'h1);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    for (int a = 0; a < 16; a += 4) begin
      rd(a[3:0], d); check("R1 reset read", d, 32'h0);
    end
  endtask

  task automatic t_first_capture();
    logic [31:0] d;
    bus_err(32'hDEAD_BEEF, 4'h7, 6'b000100, 5'b01000, 1);
    rd(4'h0, d); check("R7 data gated before sync", d, 32'h0);
    wait_valid();
    expect_rec("first", 32'hDEAD_BEEF, 4'h7, 6'b000100, 5'b01000);
    @(negedge per_clk);
    check("R8 rd_data holds without rd_en", rd_data, 32'h1);
  endtask

  task automatic t_consecutive();
    do_reset();
    @(negedge bus_clk);
    err_strobe = 1; bus_addr = 32'h1111_0000; bus_cmd = 4'h3; xfer_src = 6'b000001;
    req_grant = 5'b00001; host_mode = 1;
    @(negedge bus_clk); bus_addr = 32'h2222_0000; bus_cmd = 4'hA; xfer_src = 6'b100000;
    req_grant = 5'b10000;
    @(negedge bus_clk); bus_addr = 32'h3333_0000;
    @(negedge bus_clk); err_strobe = 0;
    wait_valid();
    expect_rec("R6 consecutive", 32'h1111_0000, 4'h3, 6'b000001, 5'b00001);
  endtask

  task automatic t_during_crossing();
    do_reset();
    bus_err(32'h0000_4000, 4'h6, 6'b010000, 5'b00100, 1);
    bus_err(32'hFFFF_FFFF, 4'hF, 6'b100000, 5'b10000, 1);
    wait_valid();
    bus_err(32'h5555_5555, 4'h1, 6'b000010, 5'b00010, 1);
    repeat (4) @(negedge per_clk);
    expect_rec("R6 during crossing", 32'h0000_4000, 4'h6, 6'b010000, 5'b00100);
  endtask

  task automatic t_non_host();
    do_reset();
    bus_err(32'h8000_0010, 4'hC, 6'b100000, 5'b00010, 0);
    wait_valid();
    expect_rec("R5 non-host", 32'h8000_0010, 4'hC, 6'b100000, 5'b00000);
  endtask

  task automatic t_rearm();
    logic [31:0] d;
    do_reset();
    rd(4'hC, d); check("R9 cleared after reset", d, 32'h0);
    rd(4'h0, d); check("R9 addr cleared", d, 32'h0);
    bus_err(32'h0BAD_F00D, 4'h2, 6'b001000, 5'b00001, 1);
    wait_valid();
    expect_rec("R9 rearm", 32'h0BAD_F00D, 4'h2, 6'b001000, 5'b00001);
  endtask

  initial begin
    t_reset_state();
    t_first_capture();
    t_consecutive();
    t_during_crossing();
    t_non_host();
    t_rearm();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule